// File: doc/BRIEF.md
# Scan-Point Laser Trigger and Serial TDC Capture

This block runs the acquisition sequence for one scan point of a raster-scanning range sensor. A start pulse makes it fire a laser trigger pulse of fixed length. It then waits for a programmable number of clock cycles and marks the end of the acquisition window with a one-cycle STOP strobe.

After the STOP strobe the block accepts a serial stream of time-to-digital result words. The stream is sampled one bit per enabled clock, most significant bit first. Each 32-bit word carries a channel tag and a pulse position. The block writes the words into a local buffer in the order they arrive. It checks each tag against the channel it expects next. The channels arrive in groups of four, and the groups arrive one after another.

When the word for the last channel has been stored, the block emits a one-cycle done pulse. A frame sequencer or a DMA request can use this pulse. The buffer has a registered read port, so the stored words can be drained from it.

Top module: `tdc_point_capture`

## Requirements
- R1: A start pulse seen while idle drives `laser_trig_o` high from the next cycle for exactly TRIG_CYC cycles (default 4).
- R2: `stop_o` rises exactly W cycles after `laser_trig_o` falls. W is the value of `acq_win_i` latched at the accepted start, and a value of 0 acts as 1.
- R3: `stop_o` is high for exactly one cycle per point and is never high together with `laser_trig_o`.
- R4: Serial bits offered before `stop_o` rises, or while the block is idle, are discarded and do not shift into any word.
- R5: A result word is assembled from 32 sampled bits (`ser_valid_i` high), most significant bit first. Bits 31:20 are the channel tag and bits 19:0 are the pulse position.
- R6: The k-th word of a point (k = 0..15) is stored at buffer address k. Reading address a with `rd_addr_i` returns that word on `rd_data_o` one cycle later.
- R7: The expected tag for the k-th word is k, so channels 0..15 arrive as four groups of four. A mismatch sets `seq_err_o` and the word is still stored. The flag holds until the next accepted start, which clears it.
- R8: `done_o` is a one-cycle pulse that rises on the clock edge that stores the sixteenth word. `busy_o` falls on the same edge.
- R9: A start pulse while `busy_o` is high is ignored. It causes no second trigger and does not change the STOP timing or the capture.
- R10: After reset `laser_trig_o`, `stop_o`, `busy_o`, `done_o` and `seq_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of one scan point |
| acq_win_i | input | 16 | Acquisition window length in cycles, latched at start |
| ser_valid_i | input | 1 | Serial bit strobe |
| ser_bit_i | input | 1 | Serial data bit, MSB first |
| rd_addr_i | input | 4 | Buffer read address |
| laser_trig_o | output | 1 | Laser trigger pulse |
| stop_o | output | 1 | End-of-window STOP strobe |
| busy_o | output | 1 | Point sequence in progress |
| done_o | output | 1 | All channel words stored (one cycle) |
| seq_err_o | output | 1 | A channel tag arrived out of order |
| rd_data_o | output | 32 | Buffer read data, one cycle latency |

## Verification
The bench aims at the window corners W = 0 and W = 1. A design that skips the zero guard would wait 65536 cycles, and a design off by one would put STOP in the wrong cycle.

The bench sends serial bits during the window. A receiver that was enabled too early would shift these bits into the words and corrupt every word that follows. It also raises start during the window. A design that re-armed on this pulse would fire a second trigger or stretch the window.

Out-of-order tags check two things. The flag must be set, and the word must still be stored. A design that dropped the word would leave a hole in the buffer. A design that never cleared the flag would report a stale error on the next clean point.

Done is checked in the exact cycle. A design that raised it one edge late, or for two cycles, would fail.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRIG,
    ST_WIN,
    ST_CAP
  } acq_st_e;
endpackage

// File: rtl/tdc_serial_rx.sv
module tdc_serial_rx #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_v,
  input  logic              bit_d,
  output logic [WORD_W-1:0] word_o,
  output logic              word_v_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  bcnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bcnt     <= '0;
      word_v_o <= 1'b0;
    end else begin
      word_v_o <= 1'b0;
      if (en && bit_v) begin
        shreg <= {shreg[WORD_W-2:0], bit_d};
        bcnt  <= bcnt + 1'b1;
        if (bcnt == CNT_W'(WORD_W-1)) word_v_o <= 1'b1;
      end
    end
  end

  assign word_o = shreg;

  // R5
  word_gap_chk: assert property (@(posedge clk) disable iff (rst)
    word_v_o |=> !word_v_o);
endmodule

// File: rtl/tdc_word_buf.sv
module tdc_word_buf #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [WORD_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [WORD_W-1:0] rd
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/tdc_acq_timer.sv
module tdc_acq_timer
  import tdc_pkg::*;
#(
  parameter int TRIG_CYC = 4,
  parameter int WIN_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             finish_i,
  output logic             accept_o,
  output logic             cap_o,
  output logic             busy_o,
  output logic             laser_o,
  output logic             stop_o
);
  acq_st_e          st;
  logic [WIN_W-1:0] cnt;
  logic [WIN_W-1:0] win_lat;

  assign accept_o = (st == ST_IDLE) && start_i;
  assign cap_o    = (st == ST_CAP);
  assign busy_o   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      win_lat <= '0;
      laser_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          st      <= ST_TRIG;
          laser_o <= 1'b1;
          cnt     <= '0;
          win_lat <= (win_i == '0) ? WIN_W'(1) : win_i;
        end
        ST_TRIG: if (cnt == WIN_W'(TRIG_CYC-1)) begin
          st      <= ST_WIN;
          laser_o <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_WIN: if (cnt == win_lat - 1'b1) begin
          st     <= ST_CAP;
          stop_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          stop_o <= 1'b0;
          if (finish_i) st <= ST_IDLE;
        end
      endcase
    end
  end

  // R1
  trig_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start_i) |=> laser_o);
  // R3
  stop_single_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);
  // R3
  trig_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(laser_o && stop_o));
  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WIN) |=> !laser_o);
endmodule

// File: rtl/tdc_point_capture.sv
module tdc_point_capture #(
  parameter int TRIG_CYC   = 4,
  parameter int WIN_W      = 16,
  parameter int NUM_GRP    = 4,
  parameter int CH_PER_GRP = 4,
  parameter int WORD_W     = 32,
  parameter int TAG_W      = 12,
  localparam int NUM_CH    = NUM_GRP * CH_PER_GRP,
  localparam int PTR_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  acq_win_i,
  input  logic              ser_valid_i,
  input  logic              ser_bit_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic              laser_trig_o,
  output logic              stop_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              seq_err_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic              accept, cap, finish, word_v, wr_en, tag_bad;
  logic [WORD_W-1:0] word;
  logic [PTR_W-1:0]  wr_ptr;

  tdc_acq_timer #(.TRIG_CYC(TRIG_CYC), .WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .win_i(acq_win_i),
    .finish_i(finish), .accept_o(accept), .cap_o(cap), .busy_o(busy_o),
    .laser_o(laser_trig_o), .stop_o(stop_o)
  );

  tdc_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .clr(accept), .en(cap), .bit_v(ser_valid_i),
    .bit_d(ser_bit_i), .word_o(word), .word_v_o(word_v)
  );

  tdc_word_buf #(.DEPTH(NUM_CH), .WORD_W(WORD_W)) u_buf (
    .clk(clk), .we(wr_en), .wa(wr_ptr), .wd(word), .ra(rd_addr_i),
    .rd(rd_data_o)
  );

  assign wr_en   = word_v && cap;
  assign finish  = wr_en && (wr_ptr == PTR_W'(NUM_CH-1));
  assign tag_bad = word[WORD_W-1 -: TAG_W] != TAG_W'(wr_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      done_o    <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (accept) begin
        wr_ptr    <= '0;
        seq_err_o <= 1'b0;
      end else if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (tag_bad) seq_err_o <= 1'b1;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_err_o) && !$past(accept)) |-> seq_err_o);
endmodule

// File: tb/test_tdc_point_capture.sv
module test_tdc_point_capture;
  logic        clk = 0;
  logic        rst = 1;
  logic        start_i = 0;
  logic [15:0] acq_win_i = 0;
  logic        ser_valid_i = 0;
  logic        ser_bit_i = 0;
  logic [3:0]  rd_addr_i = 0;
  logic        laser_trig_o, stop_o, busy_o, done_o, seq_err_o;
  logic [31:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_words [16];

  always #2 clk = ~clk;

  tdc_point_capture i_tdc_point_capture (
    .clk(clk), .rst(rst), .start_i(start_i), .acq_win_i(acq_win_i),
    .ser_valid_i(ser_valid_i), .ser_bit_i(ser_bit_i), .rd_addr_i(rd_addr_i),
    .laser_trig_o(laser_trig_o), .stop_o(stop_o), .busy_o(busy_o),
    .done_o(done_o), .seq_err_o(seq_err_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] mk_word(input int tag, input logic [19:0] pos);
    return {12'(tag), pos};
  endfunction

  function automatic int eff_win(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input bit gaps);
    for (int b = 31; b >= 0; b--) begin
      if (gaps && ($urandom % 4 == 0)) begin
        ser_valid_i = 0;
        @(negedge clk);
      end
      ser_valid_i = 1;
      ser_bit_i   = w[b];
      @(negedge clk);
    end
    ser_valid_i = 0;
  endtask

  task automatic run_point(input int w, input bit junk, input int bad_idx);
    int cnt;
    int hi;
    bit exp_err;
    start_i   = 1;
    acq_win_i = 16'(w);
    @(negedge clk);
    start_i   = 0;
    acq_win_i = 16'($urandom);
    hi = 0;
    while (laser_trig_o && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == 4, "R1 trigger length", hi, 4);
    cnt = 0;
    while (!stop_o && cnt < 70000) begin
      if (laser_trig_o) chk(0, "R9 retrigger", 1, 0);
      if (junk) begin
        ser_valid_i = 1;
        ser_bit_i   = 1'($urandom);
        start_i     = (cnt == 0);
      end
      cnt++;
      @(negedge clk);
    end
    ser_valid_i = 0;
    start_i     = 0;
    chk(cnt == eff_win(w), "R2 stop delay", cnt, eff_win(w));
    chk(!laser_trig_o, "R3 stop exclusive", laser_trig_o, 0);
    @(negedge clk);
    chk(!stop_o, "R3 stop width", stop_o, 0);
    exp_err = 0;
    for (int k = 0; k < 16; k++) begin
      int tag;
      tag = (k == bad_idx) ? k + 1 + ($urandom % 7) : k;
      if (k == bad_idx) exp_err = 1;
      exp_words[k] = mk_word(tag, 20'($urandom));
      send_word(exp_words[k], k % 3 == 1);
      if (k == 15) begin
        chk(!done_o, "R8 done early", done_o, 0);
        @(negedge clk);
        chk(done_o, "R8 done rise", done_o, 1);
        chk(!busy_o, "R8 busy falls", busy_o, 0);
        @(negedge clk);
        chk(!done_o, "R8 done width", done_o, 0);
      end
    end
    chk(seq_err_o == exp_err, "R7 sequence flag", seq_err_o, exp_err);
    for (int a = 0; a < 16; a++) begin
      rd_addr_i = 4'(a);
      @(negedge clk);
      chk(rd_data_o == exp_words[a], junk ? "R4 R6 buffer word" : "R5 R6 buffer word",
          rd_data_o, exp_words[a]);
    end
    ser_valid_i = 1;
    ser_bit_i   = 1;
    repeat (5) @(negedge clk);
    ser_valid_i = 0;
    chk(!laser_trig_o && !busy_o, "R4 idle bits ignored", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_7DC1));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({laser_trig_o, stop_o, busy_o, done_o, seq_err_o} == 5'b0, "R10 reset state",
        {laser_trig_o, stop_o, busy_o, done_o, seq_err_o}, 0);
    run_point(0, 0, -1);
    run_point(1, 1, -1);
    run_point(7, 0, 5);
    run_point(12, 1, -1);
    chk(!seq_err_o, "R7 flag cleared", seq_err_o, 0);
    run_point(3, 0, 15);
    for (int i = 0; i < 4; i++) begin
      run_point(1 + ($urandom % 40), $urandom % 2, ($urandom % 2) ? int'($urandom % 16) : -1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule